// File: doc/BRIEF.md
# Stored-Waveform Four-Phase Carrier Modulator

This block turns a serial bit stream into a sampled four-phase (QPSK) carrier without any arithmetic in the sample path. Incoming bits are grouped two at a time into a symbol. The symbol picks one of four read-only waveform tables, and each table holds exactly one carrier period at one of the four phase positions. An address counter walks through the chosen table and produces one signed sample per clock. Every symbol is therefore rendered as one whole carrier period.

The table contents come from a constant function during elaboration, so no memory image is loaded. The function builds each cosine from a fixed-point series. A symbol is only swapped in at the boundary between two periods, so the output never jumps in the middle of a period. When no fresh symbol is waiting at that boundary, the same period is played again.

Control is a two-state machine. `ST_WAIT` holds the output quiet at zero while no symbol has yet been received. `ST_PLAY` streams samples. Three transitions exist:
- *first-pair* moves `ST_WAIT` to `ST_PLAY` once a complete pair is waiting, and starts at address 0.
- *wrap-load* stays in `ST_PLAY` and adopts the waiting symbol when the address wraps.
- *wrap-repeat* stays in `ST_PLAY` and keeps the old symbol when nothing is waiting at the wrap.

Top module: `qpsk_rom_modulator`

## Requirements
- R1: While `rst_n` is low, and after reset until the first complete bit pair is accepted, `samp_vld` is 0 and `samp_out` is 0.
- R2: Accepted bits are paired in arrival order. The first bit of a pair is the symbol MSB and the second bit is the LSB.
- R3: Sample k (k = 0..49) of symbol s equals round(255 × cos(2πk/50 + φ)), as a 9-bit two's-complement value. The phase φ is 45° for s=11, 135° for s=10, 225° for s=00 and 315° for s=01.
- R4: If the second bit of the first pair is accepted at clock edge E, then `samp_vld` is still 0 after E. After edge E+1, `samp_vld` is 1 and sample 0 of that symbol is on `samp_out`.
- R5: While playing, the sample index advances by one on every clock, from 0 to 49, and then wraps to 0.
- R6: A pair that completes during a period takes effect only on the sample-0 clock after the next wrap. Until then, the old table keeps playing.
- R7: If no pair is waiting at a wrap, the same symbol's table is played again.
- R8: If several pairs complete within one period, only the most recent one is played at the next wrap.
- R9: Once `samp_vld` rises, it stays high on every clock until reset.
- R10: A bit is accepted only on a clock where `bit_vld` is 1. A single unpaired bit waits, for any number of clocks, for its partner.
- R11: `samp_out` is 0 whenever `samp_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | Qualifies `bit_in` on this clock |
| samp_out | output | 9 | Signed carrier sample |
| samp_vld | output | 1 | High while samples are being streamed |

## Verification
The main function is exercised with each of the four symbols held for more than one period. A mismatch there separates a wrong phase mapping, or a swapped MSB/LSB order in the pairing, from a wrong table value. A pair sent in the middle of a period distinguishes swapping at the boundary from swapping at once. Two pairs sent within one period show whether the newest or the oldest one is kept. A single bit followed by a long gap, and bit toggling with the strobe low, show whether pairing depends only on qualified bits. A reset in the middle of playback confirms that the quiet state returns and that the next symbol starts again from sample 0.

// File: rtl/qpsk_pkg.sv
package qpsk_pkg;

    typedef enum logic [0:0] {
        ST_WAIT = 1'b0,
        ST_PLAY = 1'b1
    } play_state_e;

    // phase position of a symbol in eighths of a carrier period
    function automatic int sym_phase_eighths(input int sym);
        case (sym)
            3:       return 1;   // 45 deg
            2:       return 3;   // 135 deg
            0:       return 5;   // 225 deg
            default: return 7;   // 315 deg
        endcase
    endfunction

    // round(amp * cos(2*pi*k/samples + 2*pi*ph8/8)), fixed-point series in Q30
    function automatic int carrier_sample(input int amp, input int samples,
                                          input int ph8, input int k);
        longint two_pi_q30;
        longint units;
        longint n;
        longint quarter;
        longint m;
        longint r;
        longint x;
        longint x2;
        longint tc;
        longint ts;
        longint c;
        longint s;
        longint v;
        longint scaled;
        two_pi_q30 = 64'sd6746518852;
        units      = 8 * longint'(samples);
        quarter    = 2 * longint'(samples);
        n          = (8 * longint'(k) + longint'(ph8) * longint'(samples)) % units;
        m          = n / quarter;
        r          = n % quarter;
        x          = (r * two_pi_q30) / units;
        x2         = (x * x) >>> 30;
        tc         = 64'sd1 <<< 30;
        c          = tc;
        ts         = x;
        s          = ts;
        for (int i = 1; i <= 10; i++) begin
            tc = -((tc * x2) >>> 30) / longint'((2 * i - 1) * (2 * i));
            c  = c + tc;
            ts = -((ts * x2) >>> 30) / longint'((2 * i) * (2 * i + 1));
            s  = s + ts;
        end
        case (m)
            0:       v = c;
            1:       v = -s;
            2:       v = -c;
            default: v = s;
        endcase
        scaled = longint'(amp) * v;
        return int'((scaled + (64'sd1 <<< 29)) >>> 30);
    endfunction

endpackage

// File: rtl/qpsk_bit_pairer.sv
module qpsk_bit_pairer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_in,
    input  logic       bit_vld,
    input  logic       take,
    output logic [1:0] pend_sym,
    output logic       pend_ok
);

    logic half_q;
    logic first_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q   <= 1'b0;
            first_q  <= 1'b0;
            pend_sym <= 2'b00;
            pend_ok  <= 1'b0;
        end else begin
            if (bit_vld && half_q) begin
                pend_sym <= {first_q, bit_in};
                pend_ok  <= 1'b1;
                half_q   <= 1'b0;
            end else begin
                if (bit_vld) begin
                    first_q <= bit_in;
                    half_q  <= 1'b1;
                end
                if (take) begin
                    pend_ok <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/qpsk_phase_rom.sv
module qpsk_phase_rom #(
    parameter int PH8     = 1,
    parameter int SAMPLES = 50,
    parameter int SW      = 9,
    parameter int AMP     = 255,
    localparam int AW     = $clog2(SAMPLES)
) (
    input  logic [AW-1:0]        addr,
    output logic signed [SW-1:0] data
);

    import qpsk_pkg::*;

    logic signed [SW-1:0] words [SAMPLES];

    for (genvar k = 0; k < SAMPLES; k++) begin : g_word
        assign words[k] = SW'(carrier_sample(AMP, SAMPLES, PH8, k));
    end

    assign data = words[addr];

endmodule

// File: rtl/qpsk_table_bank.sv
module qpsk_table_bank #(
    parameter int SAMPLES = 50,
    parameter int SW      = 9,
    parameter int AMP     = 255,
    localparam int AW     = $clog2(SAMPLES),
    localparam int NSYM   = 4
) (
    input  logic [1:0]           sym,
    input  logic [AW-1:0]        addr,
    output logic signed [SW-1:0] data
);

    import qpsk_pkg::*;

    logic signed [SW-1:0] rom_q [NSYM];

    for (genvar s = 0; s < NSYM; s++) begin : g_rom
        qpsk_phase_rom #(
            .PH8     (sym_phase_eighths(s)),
            .SAMPLES (SAMPLES),
            .SW      (SW),
            .AMP     (AMP)
        ) u_rom (
            .addr (addr),
            .data (rom_q[s])
        );
    end

    always_comb begin
        unique case (sym)
            2'b00:   data = rom_q[0];
            2'b01:   data = rom_q[1];
            2'b10:   data = rom_q[2];
            default: data = rom_q[3];
        endcase
    end

endmodule

// File: rtl/qpsk_rom_modulator.sv
module qpsk_rom_modulator #(
    parameter int SAMPLES = 50,
    parameter int SW      = 9,
    parameter int AMP     = 255
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_in,
    input  logic                 bit_vld,
    output logic signed [SW-1:0] samp_out,
    output logic                 samp_vld
);

    import qpsk_pkg::*;

    localparam int AW = $clog2(SAMPLES);
    localparam logic [AW-1:0] LAST = AW'(SAMPLES - 1);

    play_state_e          state;
    play_state_e          state_nx;
    logic [1:0]           cur_sym;
    logic [AW-1:0]        rd_addr;
    logic [1:0]           pend_sym;
    logic                 pend_ok;
    logic                 take;
    logic                 at_last;
    logic signed [SW-1:0] rom_q;

    qpsk_bit_pairer u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_in   (bit_in),
        .bit_vld  (bit_vld),
        .take     (take),
        .pend_sym (pend_sym),
        .pend_ok  (pend_ok)
    );

    qpsk_table_bank #(
        .SAMPLES (SAMPLES),
        .SW      (SW),
        .AMP     (AMP)
    ) u_bank (
        .sym  (cur_sym),
        .addr (rd_addr),
        .data (rom_q)
    );

    assign at_last = (rd_addr == LAST);

    // next state and symbol hand-over
    always_comb begin
        state_nx = state;
        take     = 1'b0;
        unique case (state)
            ST_WAIT: begin
                if (pend_ok) begin
                    state_nx = ST_PLAY;   // first-pair
                    take     = 1'b1;
                end
            end
            ST_PLAY: begin
                if (at_last && pend_ok) begin
                    take = 1'b1;          // wrap-load
                end
            end
            default: state_nx = ST_WAIT;
        endcase
    end

    // state register, symbol and sample counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_WAIT;
            cur_sym <= 2'b00;
            rd_addr <= '0;
        end else begin
            state <= state_nx;
            if (take) begin
                cur_sym <= pend_sym;
            end
            if (state == ST_PLAY) begin
                rd_addr <= at_last ? '0 : rd_addr + 1'b1;
            end else begin
                rd_addr <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_PLAY: begin
                samp_vld = 1'b1;
                samp_out = rom_q;
            end
            default: begin
                samp_vld = 1'b0;
                samp_out = '0;
            end
        endcase
    end

endmodule

// File: rtl/qpsk_rom_modulator_chk.sv
module qpsk_rom_modulator_chk #(
    parameter int SAMPLES = 50,
    parameter int SW      = 9,
    parameter int AMP     = 255,
    localparam int AW     = $clog2(SAMPLES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 samp_vld,
    input logic signed [SW-1:0] samp_out,
    input logic [AW-1:0]        rd_addr,
    input logic [1:0]           cur_sym
);

    localparam logic [AW-1:0] LAST = AW'(SAMPLES - 1);

    // R5
    addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_vld && rd_addr == LAST) |=> (rd_addr == '0));

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_vld && rd_addr != LAST) |=> (rd_addr == AW'($past(rd_addr) + 1'b1)));

    // R6
    sym_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_vld && rd_addr != LAST) |=> $stable(cur_sym));

    // R9
    vld_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        samp_vld |=> samp_vld);

    // R11
    quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_vld |-> (samp_out == '0));

    // R3
    amp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(samp_out) <= AMP) && (int'(samp_out) >= -AMP));

endmodule

bind qpsk_rom_modulator qpsk_rom_modulator_chk #(
    .SAMPLES (SAMPLES),
    .SW      (SW),
    .AMP     (AMP)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .samp_vld (samp_vld),
    .samp_out (samp_out),
    .rd_addr  (rd_addr),
    .cur_sym  (cur_sym)
);

// File: tb/test_qpsk_rom_modulator.sv
`timescale 1ns/1ps
module test_qpsk_rom_modulator;

    localparam int NS = 50;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bit_in = 1'b0;
    logic              bit_vld = 1'b0;
    logic signed [8:0] samp_out;
    logic              samp_vld;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // bench expectation state, derived from the requirements
    bit         m_play;
    int         m_k;
    logic [1:0] m_cur;
    logic [1:0] m_pend;
    bit         m_pend_ok;
    bit         m_half;
    logic       m_first;

    always #4 clk = ~clk;

    qpsk_rom_modulator i_qpsk_rom_modulator (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_in   (bit_in),
        .bit_vld  (bit_vld),
        .samp_out (samp_out),
        .samp_vld (samp_vld)
    );

    function automatic int ref_sample(input logic [1:0] s, input int k);
        real pi;
        real ph;
        real v;
        pi = 3.14159265358979;
        case (s)
            2'b11:   ph = 45.0;
            2'b10:   ph = 135.0;
            2'b00:   ph = 225.0;
            default: ph = 315.0;
        endcase
        v = 255.0 * $cos(2.0 * pi * real'(k) / real'(NS) + ph * pi / 180.0);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_play = 0; m_k = 0; m_cur = 2'b00; m_pend = 2'b00;
        m_pend_ok = 0; m_half = 0; m_first = 1'b0;
    endtask

    // one clock: drive at negedge, model the edge, compare at next negedge
    task automatic step(input logic v, input logic b, input string req);
        if (m_play) begin
            if (m_k == NS - 1) begin
                m_k = 0;
                if (m_pend_ok) begin m_cur = m_pend; m_pend_ok = 0; end
            end else begin
                m_k++;
            end
        end else if (m_pend_ok) begin
            m_play = 1; m_k = 0; m_cur = m_pend; m_pend_ok = 0;
        end
        if (v) begin
            if (m_half) begin
                m_pend = {m_first, b}; m_pend_ok = 1; m_half = 0;
            end else begin
                m_first = b; m_half = 1;
            end
        end
        bit_vld = v;
        bit_in  = b;
        @(negedge clk);
        bit_vld = 1'b0;
        chk(req, "samp_vld", int'(samp_vld), int'(m_play));
        chk(req, "samp_out", int'(samp_out), m_play ? ref_sample(m_cur, m_k) : 0);
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, req);
    endtask

    task automatic send_pair(input logic [1:0] s, input string req);
        step(1'b1, s[1], req);
        step(1'b1, s[0], req);
    endtask

    task automatic t_reset(input string req);
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        for (int i = 0; i < 3; i++) begin
            bit_vld = 1'b1;
            bit_in  = 1'b1;
            @(negedge clk);
            chk(req, "samp_vld in reset", int'(samp_vld), 0);
            chk(req, "samp_out in reset", int'(samp_out), 0);
        end
        bit_vld = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_ignored_bits();
        for (int i = 0; i < 12; i++) begin
            bit_in = i[0];
            @(negedge clk);
            chk("R10", "samp_vld unqualified", int'(samp_vld), 0);
            chk("R1", "samp_out before pair", int'(samp_out), 0);
        end
        bit_in = 1'b0;
    endtask

    task automatic t_first_pair();
        send_pair(2'b11, "R4");
        step(1'b0, 1'b0, "R4");
        idle(NS + 5, "R5");
    endtask

    task automatic t_all_phases();
        send_pair(2'b10, "R2");
        idle(2 * NS, "R3");
        send_pair(2'b00, "R3");
        idle(2 * NS, "R3");
        send_pair(2'b01, "R2");
        idle(2 * NS, "R3/R11");
    endtask

    task automatic t_repeat();
        idle(2 * NS + 7, "R7/R9");
    endtask

    task automatic t_midcycle();
        while (m_k != 20) step(1'b0, 1'b0, "R6");
        send_pair(2'b11, "R6");
        idle(NS, "R6");
    endtask

    task automatic t_overwrite();
        while (m_k != 5) step(1'b0, 1'b0, "R8");
        send_pair(2'b00, "R8");
        idle(3, "R8");
        send_pair(2'b10, "R8");
        idle(NS + 10, "R8");
    endtask

    task automatic t_lone_bit();
        step(1'b1, 1'b0, "R10");
        for (int i = 0; i < 30; i++) step(1'b0, 1'b1, "R10");
        step(1'b1, 1'b1, "R10");
        idle(NS + 10, "R10");
    endtask

    task automatic t_reset_mid();
        t_reset("R1");
        idle(5, "R1");
        send_pair(2'b00, "R4");
        idle(NS + 3, "R9");
    endtask

    initial begin
        model_reset();
        t_reset("R1");
        t_ignored_bits();
        t_first_pair();
        t_all_phases();
        t_repeat();
        t_midcycle();
        t_overwrite();
        t_lone_bit();
        t_reset_mid();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule